// File: doc/BRIEF.md
# ADC Conversion Timing Sequencer

This block drives a successive-approximation ADC from one 8-bit control register. The register selects how far the master clock is divided to make the ADC clock. It also sets how many ADC clocks the track-and-hold samples, and which start sources are accepted. A conversion begins when software asks for it, when a timer overflow pulse arrives, or on a low-going edge of an asynchronous start pin.

After a start, `trk` stays high for the acquisition period. Sixteen ADC clocks of conversion follow. In the first twelve of them the block presents a trial code on `dac_code`, asserts `step` for the master clock that samples `cmp_in`, and keeps or drops the trial bit, most significant bit first. The last four clocks give settle time. The result is then latched and `done` pulses for one master clock while `busy` falls.

The comparator, DAC and reference sit outside the block. The block passes the reference-select bit through on `ext_ref`, and the mode bit through on `pwr_up`.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the control register reads 0x40, and `busy`, `done`, `trk`, `pwr_up` are 0 while `ext_ref` is 1. Register bit 7 is `pwr_up` and bit 6 is `ext_ref`.
- R2: While register bit 7 (mode) is 0, no start source can begin a conversion. Writing bit 7 to 0 during a conversion ends it at that edge, with no `done`.
- R3: Register bits 5:4 set the ADC clock period in master clocks: 00 gives 32, 01 gives 4, 10 gives 8, 11 gives 2. The trigger edge and `done` are (A+16)×D master clocks apart, where D is this period and A is the acquisition length.
- R4: Register bits 3:2 set A: 00 gives 1 ADC clock, 01 gives 2, 10 gives 3, 11 gives 4. `trk` is high for exactly A×D master clocks after the start.
- R5: Each conversion gives exactly 12 `step` strobes and resolves the result MSB first. A bit is kept when `cmp_in` is 1 for a trial code that has that bit set. The result is the largest code that the comparator reports as not above the input.
- R6: `done` is high for one master clock. `busy` is low in that cycle and `result` already holds the new value.
- R7: A one-cycle `tmr_ovf` pulse starts a conversion only when register bit 1 is 1.
- R8: A falling edge on `conv_n` starts a conversion only when register bit 0 is 1. One low pulse of any length gives exactly one conversion.
- R9: Start requests of every kind that arrive while `busy` is high are ignored.
- R10: A write to bits 5:4 during a conversion does not change that conversion's timing. It does apply to the next conversion.
- R11: A `sw_start` pulse starts a conversion whenever mode is 1, whatever the trigger-enable bits hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register contents |
| sw_start | input | 1 | Software start pulse |
| tmr_ovf | input | 1 | Timer overflow pulse |
| conv_n | input | 1 | Asynchronous active-low external start |
| cmp_in | input | 1 | Comparator: 1 when input ≥ trial code |
| pwr_up | output | 1 | Converter power-up (mode bit) |
| ext_ref | output | 1 | External reference select |
| trk | output | 1 | Track-and-hold in track phase |
| step | output | 1 | Comparator sample strobe for the current bit |
| dac_code | output | 12 | Trial code for the DAC |
| result | output | 12 | Last completed conversion |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
A wrong divider count or a wrong acquisition length changes when `done` arrives, and also shows in how long `trk` stays high. Both show up within one conversion of at most 640 master clocks. A fault in the successive-approximation register or in its bit pointer gives a result that differs from the bench's comparator model as soon as that bit is resolved, and it appears at the next `done`. Faults in trigger gating or edge detection show up as a missing or an extra `done` within the observation window that follows the stimulus.

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int RES_W     = 12,
  parameter int CONV_CLKS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [7:0]       cfg_wdata,
  output logic [7:0]       cfg_rdata,
  input  logic             sw_start,
  input  logic             tmr_ovf,
  input  logic             conv_n,
  input  logic             cmp_in,
  output logic             pwr_up,
  output logic             ext_ref,
  output logic             trk,
  output logic             step,
  output logic [RES_W-1:0] dac_code,
  output logic [RES_W-1:0] result,
  output logic             busy,
  output logic             done
);
  localparam int CW = $clog2(CONV_CLKS + 5);
  localparam int KW = $clog2(RES_W);

  logic [7:0]       cfg;
  logic [2:0]       pin_s;
  logic [5:0]       div_lat;
  logic [4:0]       divcnt;
  logic [2:0]       acq_lat;
  logic [CW-1:0]    tcnt;
  logic [RES_W-1:0] sar;

  function automatic logic [5:0] div_of(input logic [1:0] c);
    case (c)
      2'b00:   return 6'd32;
      2'b01:   return 6'd4;
      2'b10:   return 6'd8;
      default: return 6'd2;
    endcase
  endfunction

  wire pin_fall = pin_s[2] & ~pin_s[1];
  wire abort    = ~cfg[7] | (cfg_we & ~cfg_wdata[7]);
  wire trig     = cfg[7] & ~busy & (sw_start | (cfg[1] & tmr_ovf) | (cfg[0] & pin_fall));

  wire            tick   = busy && ({1'b0, divcnt} == div_lat - 6'd1);
  wire            conv   = busy && (tcnt >= CW'(acq_lat));
  wire [CW-1:0]   kk     = tcnt - CW'(acq_lat);
  wire            bitsel = conv && (kk < CW'(RES_W));
  wire [KW-1:0]   bpos   = KW'(RES_W - 1) - kk[KW-1:0];
  wire            last   = tick && conv && (kk == CW'(CONV_CLKS - 1));

  assign cfg_rdata = cfg;
  assign pwr_up    = cfg[7];
  assign ext_ref   = cfg[6];
  assign trk       = busy && !conv;
  assign step      = tick && bitsel;
  assign dac_code  = sar | (bitsel ? (RES_W'(1) << bpos) : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg   <= 8'h40;
      pin_s <= 3'b111;
    end else begin
      pin_s <= {pin_s[1:0], conv_n};
      if (cfg_we) cfg <= cfg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      result  <= '0;
      sar     <= '0;
      divcnt  <= '0;
      tcnt    <= '0;
      div_lat <= 6'd32;
      acq_lat <= 3'd1;
    end else begin
      done <= 1'b0;
      if (abort) begin
        busy <= 1'b0;
      end else if (trig) begin
        busy    <= 1'b1;
        sar     <= '0;
        divcnt  <= '0;
        tcnt    <= '0;
        div_lat <= div_of(cfg[5:4]);
        acq_lat <= {1'b0, cfg[3:2]} + 3'd1;
      end else if (busy) begin
        if (tick) begin
          divcnt <= '0;
          tcnt   <= tcnt + 1'b1;
          if (bitsel) sar[bpos] <= cmp_in;
          if (last) begin
            busy   <= 1'b0;
            done   <= 1'b1;
            result <= sar;
          end
        end else begin
          divcnt <= divcnt + 1'b1;
        end
      end
    end
  end

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  a_r6_done_idle:   assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  a_r2_off_idle:    assert property (@(posedge clk) disable iff (!rst_n) !pwr_up |-> !busy);
  a_r4_trk_in_busy: assert property (@(posedge clk) disable iff (!rst_n) trk |-> busy && !step);
  a_r3_div_bound:   assert property (@(posedge clk) disable iff (!rst_n) busy |-> ({1'b0, divcnt} < div_lat));
  a_r10_div_hold:   assert property (@(posedge clk) disable iff (!rst_n)
                                     (busy && !abort && !last) |=> $stable(div_lat));
  a_r5_code_fresh:  assert property (@(posedge clk) disable iff (!rst_n)
                                     (trig && !abort) |=> (dac_code == '0) && trk);
endmodule

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0, sw_start = 1'b0, tmr_ovf = 1'b0, conv_n = 1'b1;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic        cmp_in, pwr_up, ext_ref, trk, step, busy, done;
  logic [11:0] dac_code, result;
  logic [11:0] vin = '0;
  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;
  assign cmp_in = (vin >= dac_code);

  adc_seq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .sw_start(sw_start), .tmr_ovf(tmr_ovf), .conv_n(conv_n), .cmp_in(cmp_in),
    .pwr_up(pwr_up), .ext_ref(ext_ref), .trk(trk), .step(step), .dac_code(dac_code),
    .result(result), .busy(busy), .done(done)
  );

  function automatic int exp_div(input logic [1:0] c);
    case (c)
      2'b00: return 32;
      2'b01: return 4;
      2'b10: return 8;
      default: return 2;
    endcase
  endfunction

  function automatic int exp_acq(input logic [1:0] c);
    return int'(c) + 1;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic measure(input bit do_mid, input logic [7:0] mid_cfg,
                         output int cyc, output int trkc, output int stepc);
    sw_start = 1'b1;
    @(negedge clk); sw_start = 1'b0;
    cyc = 0; trkc = 0; stepc = 0;
    while (!done && cyc < 5000) begin
      if (trk) trkc++;
      if (step) stepc++;
      if (do_mid && cyc == 3) begin cfg_we = 1'b1; cfg_wdata = mid_cfg; end
      else cfg_we = 1'b0;
      @(negedge clk);
      cyc++;
    end
    cfg_we = 1'b0;
  endtask

  task automatic count_dones(input int ncyc, output int nd);
    nd = 0;
    for (int i = 0; i < ncyc; i++) begin
      @(negedge clk);
      if (done) nd++;
    end
  endtask

  task automatic run_conv(input logic [7:0] c, input logic [11:0] v);
    int cyc, trkc, stepc, n;
    vin = v;
    wr(c);
    measure(1'b0, 8'h00, cyc, trkc, stepc);
    n = (exp_acq(c[3:2]) + 16) * exp_div(c[5:4]);
    chk(cyc == n, "R3 duration", cyc, n);
    chk(trkc == exp_acq(c[3:2]) * exp_div(c[5:4]), "R4 track length", trkc,
        exp_acq(c[3:2]) * exp_div(c[5:4]));
    chk(stepc == 12, "R5 step count", stepc, 12);
    chk(result == v, "R5 result", int'(result), int'(v));
    chk(!busy, "R6 busy low with done", int'(busy), 0);
    @(negedge clk);
    chk(!done, "R6 done single cycle", int'(done), 0);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int nd, cyc, trkc, stepc;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cfg_rdata == 8'h40, "R1 reg reset", int'(cfg_rdata), 64);
    chk(!busy && !done && !trk, "R1 flags idle", int'({busy, done, trk}), 0);
    chk(ext_ref && !pwr_up, "R1 mode/ref outputs", int'({pwr_up, ext_ref}), 1);

    // R2 powered down: every source ignored
    wr(8'h73);
    sw_start = 1'b1; tmr_ovf = 1'b1; conv_n = 1'b0;
    @(negedge clk); sw_start = 1'b0; tmr_ovf = 1'b0;
    count_dones(10, nd); conv_n = 1'b1;
    chk(!busy && nd == 0, "R2 no start while off", int'(busy) + nd, 0);

    // directed corners R3 R4 R5 R11
    run_conv(8'h8C, 12'd0);
    run_conv(8'h9C, 12'd4095);
    run_conv(8'hA0, 12'd2048);
    run_conv(8'hB8, 12'd2047);
    run_conv(8'hF4, 12'd1);
    // constrained random
    for (int i = 0; i < 30; i++) begin
      logic [7:0] c;
      c = {1'b1, 1'($urandom), 2'($urandom), 2'($urandom), 2'b00};
      run_conv(c, 12'($urandom));
    end

    // R11 sw start with both trigger enables clear
    vin = 12'd1234;
    wr(8'hB0);
    measure(1'b0, 8'h00, cyc, trkc, stepc);
    chk(cyc == 34 && result == 12'd1234, "R11 sw start", int'(result), 1234);

    // R7 timer trigger gating
    wr(8'hB0);
    @(negedge clk); tmr_ovf = 1'b1; @(negedge clk); tmr_ovf = 1'b0;
    count_dones(60, nd);
    chk(nd == 0, "R7 timer disabled", nd, 0);
    wr(8'hB2);
    @(negedge clk); tmr_ovf = 1'b1; @(negedge clk); tmr_ovf = 1'b0;
    count_dones(60, nd);
    chk(nd == 1, "R7 timer enabled", nd, 1);
    wr(8'hB1);
    @(negedge clk); tmr_ovf = 1'b1; @(negedge clk); tmr_ovf = 1'b0;
    count_dones(60, nd);
    chk(nd == 0, "R7 timer needs own enable", nd, 0);

    // R8 external pin
    wr(8'hB0);
    @(negedge clk); conv_n = 1'b0; repeat (20) @(negedge clk); conv_n = 1'b1;
    count_dones(60, nd);
    chk(nd == 0, "R8 pin disabled", nd, 0);
    wr(8'hB1);
    @(negedge clk); conv_n = 1'b0; repeat (20) @(negedge clk); conv_n = 1'b1;
    count_dones(60, nd);
    chk(nd == 1, "R8 pin one pulse one conversion", nd, 1);
    @(negedge clk); conv_n = 1'b0; repeat (80) @(negedge clk); conv_n = 1'b1;
    count_dones(20, nd);
    chk(!busy && nd == 0, "R8 long low pulse no repeat", nd, 0);

    // R9 triggers while busy ignored
    wr(8'hB3);
    sw_start = 1'b1; @(negedge clk); sw_start = 1'b0;
    repeat (5) @(negedge clk);
    sw_start = 1'b1; tmr_ovf = 1'b1; conv_n = 1'b0;
    @(negedge clk); sw_start = 1'b0; tmr_ovf = 1'b0;
    repeat (4) @(negedge clk); conv_n = 1'b1;
    count_dones(120, nd);
    chk(nd == 1, "R9 busy ignores triggers", nd, 1);

    // R10 divider change mid-conversion
    vin = 12'd777;
    wr(8'hB0);
    measure(1'b1, 8'h80, cyc, trkc, stepc);
    chk(cyc == 34, "R10 old divide kept", cyc, 34);
    measure(1'b0, 8'h00, cyc, trkc, stepc);
    chk(cyc == 544, "R10 new divide next", cyc, 544);

    // R2 abort by clearing mode
    wr(8'hA0);
    sw_start = 1'b1; @(negedge clk); sw_start = 1'b0;
    repeat (10) @(negedge clk);
    wr(8'h20);
    chk(!busy, "R2 abort clears busy", int'(busy), 0);
    count_dones(200, nd);
    chk(nd == 0, "R2 abort no done", nd, 0);
    chk(!pwr_up, "R2 mode output low", int'(pwr_up), 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule